// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

The controller collects interrupt requests from eight input lines, latches each on its rising edge, hides those the mask blocks, and picks the pending line with the lowest index as the winner. It raises `int_o` toward the processor only when that winner outranks every level already in service. The processor answers with two acknowledge strobes. The first moves the winner from pending to in-service. The second places an 8-bit vector on the read data bus. That vector is made of a programmed base in the upper five bits and the level number in the lower three.

Software reaches the controller through a small synchronous register port. It has a select, read and write strobes, one address bit and 8-bit data. It uses the port to run the initialization sequence, set the mask, end interrupts one level at a time or the highest level in service, and choose which status register a low-address read returns. All strobes (`cs_i`, `rd_i`, `wr_i`, `inta_i`) are active high and are sampled on the rising clock edge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `int_o` and `rdata_oe_o` are low, and the mask, pending and in-service registers all read zero.
- R2: A rising edge on `irq_i[n]` sets pending bit n. The bit stays set until an acknowledge takes it. A line that stays high does not set the bit again.
- R3: A pending request whose mask bit is 1 does not raise `int_o`. Clearing that mask bit raises `int_o`. A read with `a0_i`=1 returns the mask.
- R4: On the first acknowledge strobe, the unmasked pending request with the lowest index sets its in-service bit and clears its pending bit. Other pending bits are left unchanged.
- R5: `int_o` is high only when some unmasked pending level is strictly lower in index than every in-service level. An equal or lower-priority request does not raise it.
- R6: On the second acknowledge strobe, `rdata_oe_o` is high and `rdata_o` equals {base[7:3], level[2:0]}, with the level being the one taken by the first strobe.
- R7: Writing 0x20 with `a0_i`=0 clears the lowest-index set in-service bit.
- R8: Writing 0x60|L with `a0_i`=0 clears in-service bit L only.
- R9: A write with `a0_i`=0 of 0x0A makes later low-address reads return the pending register. A write of 0x0B makes them return the in-service register.
- R10: A write with `a0_i`=0 and bit 4 set starts initialization. It clears the mask, pending and in-service registers and selects the pending register for reads. The next `a0_i`=1 write stores the base. A third-word write with `a0_i`=1 is expected when bit 1 of the first word was 0, and a fourth when bit 0 was 1. `int_o` stays low until the sequence is complete.
- R11: If a rising edge on line n coincides with the first acknowledge strobe that takes level n, pending bit n stays set and in-service bit n is set.
- R12: A first acknowledge strobe with nothing unmasked and pending leaves the in-service register unchanged. The next vector carries level 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Register port select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| a0_i | input | 1 | Register address bit |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data or interrupt vector |
| rdata_oe_o | output | 1 | Read data valid / bus drive enable |
| irq_i | input | 8 | Interrupt request lines, index 0 highest |
| inta_i | input | 1 | Acknowledge strobe from the processor |
| int_o | output | 1 | Interrupt request to the processor |

## Verification
The two functions that can land in the same cycle are the edge capture on a request line and the first acknowledge strobe, which clears the same pending bit. The bench first lets line 2 become pending and then drops it. It then raises that line again in exactly the cycle that carries the first acknowledge strobe. The result is judged by reading both status registers: in-service bit 2 must be set and pending bit 2 must still be set, so the fresh request survives its predecessor's acknowledge. The bench also overlaps an end-of-interrupt command with two in-service levels to show that specific and non-specific commands clear different bits.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NIRQ   = 8;
  localparam int LVL_W  = $clog2(NIRQ);
  localparam int DATA_W = 8;
  localparam int BASE_W = DATA_W - LVL_W;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_W2   = 3'd1,
    ST_W3   = 3'd2,
    ST_W4   = 3'd3,
    ST_RUN  = 3'd4
  } init_st_e;
endpackage

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  output logic         valid_o,
  output logic [W-1:0] idx_o
);
  // lowest index wins: scan down so the last hit is the smallest
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = W'(i);
    end
  end
  assign valid_o = |vec_i;
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_all_i,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] ack_clr_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] irq_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        irq_q[g] <= 1'b0;
        irr_o[g] <= 1'b0;
      end else begin
        irq_q[g] <= irq_i[g];
        if (clear_all_i)                 irr_o[g] <= 1'b0;
        else if (irq_i[g] && !irq_q[g])  irr_o[g] <= 1'b1;  // new edge beats ack
        else if (ack_clr_i[g])           irr_o[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pic_prog.sv
module pic_prog
  import pic_pkg::*;
#(
  parameter int N = NIRQ,
  parameter int W = LVL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_stb_i,
  input  logic          a0_i,
  input  logic [7:0]    wdata_i,
  output logic          init_o,
  output logic          ready_o,
  output logic          eoi_ns_o,
  output logic          eoi_sp_o,
  output logic [W-1:0]  eoi_lvl_o,
  output logic [N-1:0]  imr_o,
  output logic [BASE_W-1:0] base_o,
  output logic          rd_isr_o
);
  init_st_e st_q;
  logic need_w3_q, need_w4_q;
  logic cmd_lo;

  assign cmd_lo    = wr_stb_i && !a0_i && !wdata_i[4];
  assign init_o    = wr_stb_i && !a0_i && wdata_i[4];
  assign ready_o   = (st_q == ST_RUN);
  assign eoi_ns_o  = ready_o && cmd_lo && !wdata_i[3] && (wdata_i[7:5] == 3'b001);
  assign eoi_sp_o  = ready_o && cmd_lo && !wdata_i[3] && (wdata_i[7:5] == 3'b011);
  assign eoi_lvl_o = wdata_i[W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      need_w3_q <= 1'b0;
      need_w4_q <= 1'b0;
      imr_o     <= '0;
      base_o    <= '0;
      rd_isr_o  <= 1'b0;
    end else if (init_o) begin
      st_q      <= ST_W2;
      need_w3_q <= !wdata_i[1];
      need_w4_q <= wdata_i[0];
      imr_o     <= '0;
      rd_isr_o  <= 1'b0;
    end else if (wr_stb_i) begin
      unique case (st_q)
        ST_W2: if (a0_i) begin
          base_o <= wdata_i[7:8-BASE_W];
          st_q   <= need_w3_q ? ST_W3 : (need_w4_q ? ST_W4 : ST_RUN);
        end
        ST_W3: if (a0_i) st_q <= need_w4_q ? ST_W4 : ST_RUN;
        ST_W4: if (a0_i) st_q <= ST_RUN;
        ST_RUN: begin
          if (a0_i) imr_o <= wdata_i[N-1:0];
          else if (wdata_i[3] && wdata_i[1]) rd_isr_o <= wdata_i[0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             a0_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic             rdata_oe_o,
  input  logic [NIRQ-1:0]  irq_i,
  input  logic             inta_i,
  output logic             int_o
);
  logic              wr_stb, rd_stb;
  logic              init, ready, eoi_ns, eoi_sp, rd_isr;
  logic [LVL_W-1:0]  eoi_lvl;
  logic [NIRQ-1:0]   imr, irr_q, isr_q, pend, ack_clr, eoi_clr, isr_set;
  logic [BASE_W-1:0] base;
  logic              pend_v, isr_v;
  logic [LVL_W-1:0]  win, isr_hi, lvl_q;
  logic              phase_q, ack1, ack2;

  assign wr_stb = cs_i && wr_i;
  assign rd_stb = cs_i && rd_i;

  pic_prog #(.N(NIRQ), .W(LVL_W)) u_prog (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_stb_i(wr_stb), .a0_i(a0_i),
    .wdata_i(wdata_i), .init_o(init), .ready_o(ready), .eoi_ns_o(eoi_ns),
    .eoi_sp_o(eoi_sp), .eoi_lvl_o(eoi_lvl), .imr_o(imr), .base_o(base),
    .rd_isr_o(rd_isr)
  );

  pic_req_latch #(.N(NIRQ)) u_req (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_all_i(init), .irq_i(irq_i),
    .ack_clr_i(ack_clr), .irr_o(irr_q)
  );

  assign pend = irr_q & ~imr;

  pic_prio_enc #(.N(NIRQ), .W(LVL_W)) u_enc_req (
    .vec_i(pend), .valid_o(pend_v), .idx_o(win)
  );
  pic_prio_enc #(.N(NIRQ), .W(LVL_W)) u_enc_isr (
    .vec_i(isr_q), .valid_o(isr_v), .idx_o(isr_hi)
  );

  assign int_o = ready && pend_v && (!isr_v || (win < isr_hi));

  assign ack1    = inta_i && !phase_q;
  assign ack2    = inta_i && phase_q;
  assign isr_set = (ack1 && pend_v) ? (NIRQ'(1) << win) : '0;
  assign ack_clr = isr_set;

  always_comb begin
    eoi_clr = '0;
    if (eoi_ns && isr_v) eoi_clr = NIRQ'(1) << isr_hi;
    else if (eoi_sp)     eoi_clr = NIRQ'(1) << eoi_lvl;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q   <= '0;
      phase_q <= 1'b0;
      lvl_q   <= '0;
    end else begin
      if (init) isr_q <= '0;
      else      isr_q <= (isr_q & ~eoi_clr) | isr_set;
      if (inta_i) phase_q <= !phase_q;
      if (ack1)   lvl_q <= pend_v ? win : LVL_W'(NIRQ - 1);
    end
  end

  always_comb begin
    if (ack2)        rdata_o = {base, lvl_q};
    else if (rd_stb) rdata_o = a0_i ? DATA_W'(imr) : (rd_isr ? DATA_W'(isr_q) : DATA_W'(irr_q));
    else             rdata_o = '0;
  end
  assign rdata_oe_o = ack2 || rd_stb;
endmodule

// File: rtl/pic_checker.sv
module pic_checker
  import pic_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              int_o,
  input logic              inta_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rdata_oe_o,
  input logic [NIRQ-1:0]   irr_q,
  input logic [NIRQ-1:0]   imr,
  input logic [NIRQ-1:0]   isr_q,
  input logic              phase_q,
  input logic [LVL_W-1:0]  lvl_q,
  input logic [LVL_W-1:0]  win,
  input logic              ready,
  input logic              eoi_ns
);
  assert_masked_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irr_q & ~imr) == '0) |-> !int_o);

  assert_ack_commits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !phase_q && ((irr_q & ~imr) != '0)) |=> isr_q[$past(win)]);

  assert_vector_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && phase_q) |-> (rdata_oe_o && rdata_o[LVL_W-1:0] == lvl_q));

  assert_ns_eoi_one_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_ns && !inta_i && isr_q != '0) |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));

  assert_init_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready |-> !int_o);
endmodule

bind prio_irq_ctrl pic_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .int_o(int_o), .inta_i(inta_i),
  .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o), .irr_q(irr_q), .imr(imr),
  .isr_q(isr_q), .phase_q(phase_q), .lvl_q(lvl_q), .win(win),
  .ready(ready), .eoi_ns(eoi_ns)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cs_i = 0, rd_i = 0, wr_i = 0, a0_i = 0, inta_i = 0;
  logic [7:0] wdata_i = '0, irq_i = '0;
  logic [7:0] rdata_o;
  logic rdata_oe_o, int_o;
  int checks = 0, errors = 0;
  bit done = 0;
  localparam logic [7:0] BASE = 8'h48;

  always #2.5 clk_i = ~clk_i;

  prio_irq_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .rd_i(rd_i), .wr_i(wr_i),
    .a0_i(a0_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o),
    .irq_i(irq_i), .inta_i(inta_i), .int_o(int_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    @(negedge clk_i); cs_i = 1; wr_i = 1; a0_i = a; wdata_i = d;
    @(negedge clk_i); cs_i = 0; wr_i = 0; a0_i = 0; wdata_i = '0;
  endtask

  task automatic rd(input bit a, output logic [7:0] v);
    @(negedge clk_i); cs_i = 1; rd_i = 1; a0_i = a;
    #1 v = rdata_o;
    @(negedge clk_i); cs_i = 0; rd_i = 0; a0_i = 0;
  endtask

  task automatic rd_irr(output logic [7:0] v); wr(0, 8'h0A); rd(0, v); endtask
  task automatic rd_isr(output logic [7:0] v); wr(0, 8'h0B); rd(0, v); endtask

  task automatic raise(input int n);
    @(negedge clk_i); irq_i[n] = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic drop_all();
    @(negedge clk_i); irq_i = '0;
    @(negedge clk_i);
  endtask

  task automatic ack1();
    @(negedge clk_i); inta_i = 1;
    @(negedge clk_i); inta_i = 0;
  endtask

  task automatic ack2(output logic [7:0] v, output logic oe);
    @(negedge clk_i); inta_i = 1;
    #1 v = rdata_o; oe = rdata_oe_o;
    @(negedge clk_i); inta_i = 0;
  endtask

  task automatic init_std();
    wr(0, 8'h13); wr(1, BASE); wr(1, 8'h01);
  endtask

  task automatic drain();
    logic [7:0] v; logic oe;
    for (int k = 0; k < 8; k++) begin
      if (int_o) begin ack1(); ack2(v, oe); wr(0, 8'h20); end
    end
    for (int k = 0; k < 8; k++) wr(0, 8'h20);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check(int_o == 0, "R1 int after reset", int_o, 0);
    check(rdata_oe_o == 0, "R1 oe after reset", rdata_oe_o, 0);
    rd(1, v); check(v == 0, "R1 mask after reset", v, 0);
    rd(0, v); check(v == 0, "R1 pending after reset", v, 0);
  endtask

  task automatic t_init();
    logic [7:0] v; logic oe;
    wr(0, 8'h11);                    // needs word3 and word4
    raise(3);
    rd(0, v); check(v == 8'h08, "R10 pending read selected by init", v, 8'h08);
    wr(1, BASE);
    check(int_o == 0, "R10 int low after word2", int_o, 0);
    wr(1, 8'h00);
    check(int_o == 0, "R10 int low after word3", int_o, 0);
    wr(1, 8'h01);
    check(int_o == 1, "R10 int after full sequence", int_o, 1);
    ack1(); ack2(v, oe);
    check(oe && v == (BASE | 8'h03), "R6 vector level 3", v, BASE | 8'h03);
    wr(0, 8'h20);
    drop_all();
  endtask

  task automatic t_edge();
    logic [7:0] v;
    raise(5);
    repeat (4) @(negedge clk_i);
    rd_irr(v); check(v == 8'h20, "R2 edge latched", v, 8'h20);
    ack1();
    repeat (3) @(negedge clk_i);
    rd_irr(v); check(v == 8'h00, "R2 held line does not re-set", v, 0);
    rd_isr(v); check(v == 8'h20, "R9 isr read select", v, 8'h20);
    logic_oe_cleanup();
    wr(0, 8'h20);
    drop_all();
  endtask

  task automatic logic_oe_cleanup();
    logic [7:0] v; logic oe;
    ack2(v, oe);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    wr(1, 8'h04);
    raise(2);
    check(int_o == 0, "R3 masked request silent", int_o, 0);
    rd(1, v); check(v == 8'h04, "R3 mask readback", v, 8'h04);
    wr(1, 8'h00);
    check(int_o == 1, "R3 unmask raises int", int_o, 1);
    drain();
    drop_all();
  endtask

  task automatic t_prio();
    logic [7:0] v; logic oe;
    @(negedge clk_i); irq_i = 8'h52;
    @(negedge clk_i);
    check(int_o == 1, "R4 int on multiple", int_o, 1);
    ack1();
    rd_isr(v); check(v == 8'h02, "R4 winner in service", v, 8'h02);
    rd_irr(v); check(v == 8'h50, "R4 winner cleared others kept", v, 8'h50);
    ack2(v, oe); check(oe && v == (BASE | 8'h01), "R6 vector level 1", v, BASE | 8'h01);
    check(int_o == 0, "R5 lower priority blocked", int_o, 0);
    drop_all();
    raise(1);
    check(int_o == 0, "R5 equal priority blocked", int_o, 0);
    raise(0);
    check(int_o == 1, "R5 higher priority passes", int_o, 1);
    ack1(); ack2(v, oe);
    check(v == (BASE | 8'h00), "R6 vector level 0", v, BASE);
    rd_isr(v); check(v == 8'h03, "R4 nested in service", v, 8'h03);
    wr(0, 8'h61);
    rd_isr(v); check(v == 8'h01, "R8 specific eoi level 1", v, 8'h01);
    wr(0, 8'h20);
    rd_isr(v); check(v == 8'h00, "R7 non-specific eoi", v, 8'h00);
    drain();
    drop_all();
  endtask

  task automatic t_collide();
    logic [7:0] v; logic oe;
    raise(2);
    drop_all();
    @(negedge clk_i); inta_i = 1; irq_i[2] = 1'b1;
    @(negedge clk_i); inta_i = 0;
    rd_isr(v); check(v == 8'h04, "R11 collision in service", v, 8'h04);
    rd_irr(v); check(v == 8'h04, "R11 collision edge kept", v, 8'h04);
    ack2(v, oe);
    wr(0, 8'h20);
    drain();
    drop_all();
  endtask

  task automatic t_spurious();
    logic [7:0] v; logic oe;
    check(int_o == 0, "R12 idle before spurious", int_o, 0);
    ack1(); ack2(v, oe);
    check(oe && v == (BASE | 8'h07), "R12 spurious vector", v, BASE | 8'h07);
    rd_isr(v); check(v == 8'h00, "R12 in service unchanged", v, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_init();
    init_std();
    t_edge();
    t_mask();
    t_prio();
    t_collide();
    t_spurious();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule